// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Drive Controller

This block turns one PWM command into two gate enables for a synchronous buck stage: a high-side enable and a low-side enable. It keeps the two switches from conducting together by adaptive dead time. When the command rises, the low-side enable drops at once. The high-side enable follows only after the low side has been off for a set number of cycles. When the command falls, the high side drops at once. The low side then waits until a digitized switch-node-low flag reports that the node has fallen, or until a timeout runs out, whichever comes first.

Several overrides sit on top of this sequencing. A crowbar input has the highest priority and forces the low side on and the high side off. A supply-good flag and an active-low global shutdown both force both enables off. An active-low low-side shutdown masks only the low-side enable. The PWM, shutdown, low-side shutdown and switch-node flags pass through two-flop synchronizers. The crowbar and supply-good inputs act on the outputs in the same cycle.

Top module: `gnoc_top`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, both enables are 0 unless the crowbar input is 1.
- R2: With PWM held at 1 and no override active, the high-side enable settles to 1 and the low-side enable to 0.
- R3: After PWM falls, the high-side enable drops as soon as the synchronized PWM is low. The low-side enable rises one cycle after the synchronized switch-node-low flag is seen as 1.
- R4: If the switch-node-low flag stays 0, the low-side enable rises after the wait state has lasted TIMEOUT_CYC cycles. The timeout count restarts on every falling edge of PWM.
- R5: The high-side enable rises only after the low-side enable has been 0 for at least DEAD_CYC consecutive cycles.
- R6: If PWM returns to 1 during the switch-node wait, the wait is abandoned, the low-side enable stays 0, and the high-side enable follows after the dead time.
- R7: While the synchronized global shutdown is 0, both enables are 0 (crowbar excepted). On release, sequencing restarts from the idle phase.
- R8: While the synchronized low-side shutdown is 0, the low-side enable is 0 (crowbar excepted). The high side sequences normally.
- R9: While crowbar is 1, the low-side enable is 1 and the high-side enable is 0 in the same cycle, even with shutdown or an undervoltage condition active.
- R10: While the supply-good flag is 0, both enables are 0 in the same cycle (crowbar excepted). After recovery the controller restarts in the idle phase with both enables off.
- R11: The two enables are never 1 together unless crowbar is 1.
- R12: PWM, global shutdown, low-side shutdown and switch-node-low each reach the sequencer through two flops. A change on one of them takes effect on the third rising edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_i | input | 1 | PWM command, 1 requests the high side |
| shdn_n_i | input | 1 | Active-low global shutdown |
| ls_off_n_i | input | 1 | Active-low low-side shutdown |
| crowbar_i | input | 1 | Crowbar override, forces the low side on |
| uv_ok_i | input | 1 | Supply-good flag, 0 means undervoltage |
| sw_low_i | input | 1 | Switch node below threshold flag (asynchronous) |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |

## Verification
The bench builds the controller with TIMEOUT_CYC=12 and DEAD_CYC=3 instead of the defaults. The shorter timeout lets the fallback path complete many times within a short run. It also lets PWM be reasserted part way through the wait to exercise the abandon path. A dead time of 3 makes the low-side-off window longer than the synchronizer delay, so any off-by-one in the break phase shows up against the lockstep model. Long stretches with random stimulus and sparse override pulses cover the combinations of crowbar, shutdown, low-side shutdown and supply-good against every sequencing phase.

// File: rtl/gnoc_pkg.sv
package gnoc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LS   = 3'd1,
    PH_BRK  = 3'd2,
    PH_HS   = 3'd3,
    PH_WAIT = 3'd4
  } phase_e;
endpackage

// File: rtl/gnoc_rst_sync.sv
module gnoc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic r1_q, r2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      r1_q <= 1'b0;
      r2_q <= 1'b0;
    end else begin
      r1_q <= 1'b1;
      r2_q <= r1_q;
    end
  end

  assign rst_sync_n = r2_q;
endmodule

// File: rtl/gnoc_sync.sv
module gnoc_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= async_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gnoc_phase_fsm.sv
module gnoc_phase_fsm
  import gnoc_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 35,
  parameter int unsigned DEAD_CYC    = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwm_s,
  input  logic   sw_low_s,
  input  logic   halt,
  output phase_e phase_o
);
  localparam int unsigned MAXC    = (TIMEOUT_CYC > DEAD_CYC) ? TIMEOUT_CYC : DEAD_CYC;
  localparam int unsigned CW      = $clog2(MAXC + 1);
  localparam logic [CW-1:0] TO_LAST   = CW'(TIMEOUT_CYC - 1);
  localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYC - 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // next-state process
  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (halt) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          cnt_d = '0;
          ph_d  = pwm_s ? PH_BRK : PH_WAIT;
        end
        PH_LS: begin
          if (pwm_s) begin
            ph_d  = PH_BRK;
            cnt_d = '0;
          end
        end
        PH_BRK: begin
          if (!pwm_s) begin
            ph_d  = PH_WAIT;
            cnt_d = '0;
          end else if (cnt_q == DEAD_LAST) begin
            ph_d  = PH_HS;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_HS: begin
          if (!pwm_s) begin
            ph_d  = PH_WAIT;
            cnt_d = '0;
          end
        end
        PH_WAIT: begin
          if (pwm_s) begin
            ph_d  = PH_BRK;
            cnt_d = '0;
          end else if (sw_low_s || (cnt_q == TO_LAST)) begin
            ph_d  = PH_LS;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign phase_o = ph_q;

  // R4: a timeout exit from the wait happens only after the full count
  assert_timeout_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph_q) == PH_WAIT && ph_q == PH_LS && !$past(sw_low_s))
      |-> ($past(cnt_q) == TO_LAST));

  // R6: PWM back high during the wait abandons it without a low-side turn-on
  assert_abandon_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WAIT && pwm_s && !halt) |=> (ph_q == PH_BRK));

  // R5: the high phase is reached only from the break phase
  assert_hs_via_break_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HS && $past(ph_q) != PH_HS) |-> ($past(ph_q) == PH_BRK));
endmodule

// File: rtl/gnoc_top.sv
module gnoc_top
  import gnoc_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 35,
  parameter int unsigned DEAD_CYC    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic shdn_n_i,
  input  logic ls_off_n_i,
  input  logic crowbar_i,
  input  logic uv_ok_i,
  input  logic sw_low_i,
  output logic hs_en_o,
  output logic ls_en_o
);
  localparam int unsigned NSYNC = 4;
  localparam int unsigned DW    = $clog2(DEAD_CYC + 1);

  logic             rst_int_n;
  logic [NSYNC-1:0] raw_vec, syn_vec;
  logic             pwm_s, shdn_n_s, ls_ok_s, sw_low_s;
  logic             halt;
  phase_e           phase;

  gnoc_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign raw_vec = {sw_low_i, ls_off_n_i, shdn_n_i, pwm_i};

  gnoc_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i (raw_vec),
    .sync_o  (syn_vec)
  );

  assign pwm_s    = syn_vec[0];
  assign shdn_n_s = syn_vec[1];
  assign ls_ok_s  = syn_vec[2];
  assign sw_low_s = syn_vec[3];

  assign halt = crowbar_i | ~uv_ok_i | ~shdn_n_s;

  gnoc_phase_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC), .DEAD_CYC(DEAD_CYC)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pwm_s    (pwm_s),
    .sw_low_s (sw_low_s),
    .halt     (halt),
    .phase_o  (phase)
  );

  // output decode with override priority: crowbar, then halt, then masking
  always_comb begin
    hs_en_o = 1'b0;
    ls_en_o = 1'b0;
    if (crowbar_i) begin
      ls_en_o = 1'b1;
    end else if (!halt) begin
      hs_en_o = (phase == PH_HS);
      ls_en_o = (phase == PH_LS) & ls_ok_s;
    end
  end

  // checker state: consecutive cycles with the low side off, saturating
  logic [DW-1:0] ls_off_run_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)                            ls_off_run_q <= '0;
    else if (ls_en_o)                          ls_off_run_q <= '0;
    else if (ls_off_run_q != DW'(DEAD_CYC))    ls_off_run_q <= ls_off_run_q + 1'b1;
  end

  // R11: never both enables outside crowbar
  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hs_en_o && ls_en_o) |-> crowbar_i);

  // R9: crowbar forces low side on, high side off
  assert_crowbar_force_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    crowbar_i |-> (ls_en_o && !hs_en_o));

  // R7 / R10: shutdown or undervoltage keeps both off unless crowbar
  assert_halt_off_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!crowbar_i && (!shdn_n_s || !uv_ok_i)) |-> (!hs_en_o && !ls_en_o));

  // R5: high side rises only after the low side was off for the dead time
  assert_dead_time_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(hs_en_o) |-> (ls_off_run_q == DW'(DEAD_CYC)));

  // R8: low-side shutdown masks the low side
  assert_ls_mask_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!crowbar_i && !ls_ok_s) |-> !ls_en_o);
endmodule

// File: tb/gnoc_top_tb.sv
module gnoc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TO_C   = 12;
  localparam int DEAD_C = 3;

  logic clk = 1'b0;
  logic rst_n, pwm, shdn_n, ls_off_n, crowbar, uv_ok, sw_low;
  logic hs_en, ls_en;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  gnoc_top #(.TIMEOUT_CYC(TO_C), .DEAD_CYC(DEAD_C), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .shdn_n_i(shdn_n),
    .ls_off_n_i(ls_off_n), .crowbar_i(crowbar), .uv_ok_i(uv_ok),
    .sw_low_i(sw_low), .hs_en_o(hs_en), .ls_en_o(ls_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  // phases: 0 idle, 1 low side on, 2 break before high, 3 high on, 4 node wait
  logic rs1, rs2;
  logic [1:0] hist_p, hist_sd, hist_lo, hist_sw;  // [1] is the usable value
  int m_ph, m_rem;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 0; rs2 <= 0;
      hist_p <= 0; hist_sd <= 0; hist_lo <= 0; hist_sw <= 0;
      m_ph <= 0; m_rem <= 0;
    end else begin
      rs1 <= 1; rs2 <= rs1;
      if (!rs2) begin
        hist_p <= 0; hist_sd <= 0; hist_lo <= 0; hist_sw <= 0;
        m_ph <= 0; m_rem <= 0;
      end else begin
        hist_p  <= {hist_p[0], pwm};
        hist_sd <= {hist_sd[0], shdn_n};
        hist_lo <= {hist_lo[0], ls_off_n};
        hist_sw <= {hist_sw[0], sw_low};
        if (crowbar || !uv_ok || !hist_sd[1]) begin
          m_ph <= 0;
        end else if (hist_p[1]) begin
          if (m_ph == 3) m_ph <= 3;
          else if (m_ph == 2) begin
            if (m_rem <= 1) m_ph <= 3; else m_rem <= m_rem - 1;
          end else begin
            m_ph <= 2; m_rem <= DEAD_C;
          end
        end else begin
          if (m_ph == 1) m_ph <= 1;
          else if (m_ph == 4) begin
            if (hist_sw[1] || m_rem <= 1) m_ph <= 1; else m_rem <= m_rem - 1;
          end else begin
            m_ph <= 4; m_rem <= TO_C;
          end
        end
      end
    end
  end

  function automatic logic exp_hs();
    if (crowbar || !uv_ok || !hist_sd[1]) return 1'b0;
    return (m_ph == 3);
  endfunction

  function automatic logic exp_ls();
    if (crowbar) return 1'b1;
    if (!uv_ok || !hist_sd[1]) return 1'b0;
    return (m_ph == 1) && hist_lo[1];
  endfunction

  // lockstep comparison away from the active edge (R12 timing, R11 overlap)
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (hs_en !== exp_hs() || ls_en !== exp_ls()) begin
        failures++;
        $display("FAIL R12 lockstep t=%0t hs=%b ls=%b expected hs=%b ls=%b",
                 $time, hs_en, ls_en, exp_hs(), exp_ls());
      end
      checks++;
      if (hs_en === 1'b1 && ls_en === 1'b1 && !crowbar) begin
        failures++;
        $display("FAIL R11 overlap t=%0t hs=%b ls=%b expected not both high", $time, hs_en, ls_en);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(logic act, logic exp, string req);
    @(negedge clk);
    #1;
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic chk_now(logic act, logic exp, string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  initial begin
    rst_n = 0; pwm = 0; shdn_n = 1; ls_off_n = 1; crowbar = 0; uv_ok = 1; sw_low = 0;
    cyc(3);
    chk(hs_en, 1'b0, "R1 reset hs");
    chk(ls_en, 1'b0, "R1 reset ls");
    rst_n = 1;
    cyc(1);
    chk_now(hs_en, 1'b0, "R1 post-reset hs");
    chk_now(ls_en, 1'b0, "R1 post-reset ls");

    // R4 timeout with switch-node flag never asserting
    cyc(8);
    chk_now(ls_en, 1'b0, "R4 still waiting");
    cyc(20);
    chk_now(ls_en, 1'b1, "R4 timeout low side on");

    // R5 / R2 rise of PWM
    pwm = 1;
    cyc(3);
    chk_now(ls_en, 1'b0, "R5 low side dropped");
    chk_now(hs_en, 1'b0, "R5 high side held in dead time");
    cyc(10);
    chk_now(hs_en, 1'b1, "R2 high side on");
    chk_now(ls_en, 1'b0, "R2 low side off");

    // R3 fall with switch node already low
    sw_low = 1; cyc(4);
    pwm = 0;
    cyc(3);
    chk_now(hs_en, 1'b0, "R3 high side off");
    cyc(2);
    chk_now(ls_en, 1'b1, "R3 low side on after node low");

    // R6 abandon
    sw_low = 0; pwm = 1; cyc(10);
    chk_now(hs_en, 1'b1, "R6 high before fall");
    pwm = 0; cyc(7);
    chk_now(ls_en, 1'b0, "R6 waiting");
    pwm = 1;
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      chk_now(ls_en, 1'b0, "R6 low side stays off");
    end
    chk_now(hs_en, 1'b1, "R6 high after abandon");

    // R7 global shutdown
    shdn_n = 0; cyc(4);
    chk_now(hs_en, 1'b0, "R7 shutdown hs");
    pwm = 0; cyc(20);
    chk_now(ls_en, 1'b0, "R7 shutdown ls");
    shdn_n = 1; cyc(25);
    chk_now(ls_en, 1'b1, "R7 restart after shutdown");

    // R8 low-side shutdown
    ls_off_n = 0; cyc(4);
    chk_now(ls_en, 1'b0, "R8 masked low side");
    pwm = 1; cyc(10);
    chk_now(hs_en, 1'b1, "R8 high side unaffected");
    pwm = 0; sw_low = 1; cyc(10);
    chk_now(ls_en, 1'b0, "R8 masked after fall");
    chk_now(hs_en, 1'b0, "R8 high off after fall");
    ls_off_n = 1; cyc(4);
    chk_now(ls_en, 1'b1, "R8 unmasked");

    // R9 crowbar
    crowbar = 1; #1;
    chk_now(ls_en, 1'b1, "R9 crowbar immediate ls");
    pwm = 1; cyc(10);
    chk_now(hs_en, 1'b0, "R9 crowbar blocks hs");
    shdn_n = 0; uv_ok = 0; cyc(2);
    chk_now(ls_en, 1'b1, "R9 crowbar over shutdown and uv");
    crowbar = 0; shdn_n = 1; uv_ok = 1; cyc(1);
    chk_now(hs_en, 1'b0, "R9 release restarts off");
    cyc(12);
    chk_now(hs_en, 1'b1, "R9 high after release");

    // R10 undervoltage
    uv_ok = 0; #1;
    chk_now(hs_en, 1'b0, "R10 uv immediate hs");
    cyc(2);
    uv_ok = 1; #1;
    chk_now(hs_en, 1'b0, "R10 recovery idle hs");
    chk_now(ls_en, 1'b0, "R10 recovery idle ls");
    cyc(12);
    chk_now(hs_en, 1'b1, "R10 resumes");

    // random sweep against the model
    for (int i = 0; i < 3000; i++) begin
      cyc(1);
      if ($urandom_range(0, 9) == 0) pwm = ~pwm;
      sw_low   = ($urandom_range(0, 3) == 0);
      shdn_n   = ($urandom_range(0, 60) != 0);
      ls_off_n = ($urandom_range(0, 40) != 0);
      crowbar  = ($urandom_range(0, 80) == 0);
      uv_ok    = ($urandom_range(0, 70) != 0);
    end
    crowbar = 0; uv_ok = 1; shdn_n = 1; ls_off_n = 1;
    cyc(30);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule